// File: doc/BRIEF.md
# Scaled Compare Timer

A bus-mapped timer built around a 31-bit tick counter and four compare channels. The counter steps once per clock while either of two enable bits is set: a continuous enable, or a one-shot enable that the hardware drops by itself. A right shift of 0 to 15 places, held in the configuration word, turns the counter into a 16-bit scaled view. Each channel compares that view against its own 16-bit threshold. A channel whose threshold is reached latches a pending flag, which drives that channel's interrupt line.

Software reaches the block through a simple single-cycle register bus. The counter can be loaded in raw form, or through the scaled view, in which case the written value is shifted left by the current scale. Channel 0 can be set to reset the counter when it fires. That makes the timer periodic, and it ends a one-shot run. A one-shot run also ends when the counter wraps past its top value.

Top module: `sct_top`

## Requirements
- R1: While reset is asserted and after it is released, the configuration word, the counter and all four compare registers read as zero, and every interrupt line is low until a compare condition is met.
- R2: Offsets are configuration 0x00, raw counter 0x08, scaled view 0x10 and compare registers 0x20/0x24/0x28/0x2C for channels 0 to 3. Any other offset reads zero. Configuration bits other than scale [3:0], zero-on-compare [9], continuous enable [12], one-shot enable [13] and pending [31:28] read zero.
- R3: The counter advances by one per clock while configuration bit 12 or bit 13 is set. It holds its value while both bits are clear.
- R4: The counter is 31 bits wide and wraps from 0x7FFFFFFF to 0. A raw counter read always returns bit 31 as zero.
- R5: The scaled view reads as (counter >> scale) & 0xFFFF.
- R6: A write to the scaled view loads the counter with (value[15:0] << scale) & 0x7FFFFFFF. A raw write loads value[30:0].
- R7: A compare register keeps only bits [15:0] of a write. Its upper bits read back as zero.
- R8: One clock after channel i's scaled view becomes greater than or equal to its compare value, configuration bit 28+i and irq_o[i] go high. This also holds while the counter is stopped.
- R9: With bit 9 set, a channel-0 match resets the counter to zero and clears bit 13 on the next clock. Bit 28 is set on that same clock.
- R10: A one-shot run that wraps the counter from 0x7FFFFFFF clears bit 13, so the counter stops at zero. A continuous run keeps counting through the wrap.
- R11: A configuration write that carries 0 in bit 28+i clears channel i's pending flag and interrupt. If the channel's match condition holds on that same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus write strobe qualifier, one access per clock |
| we_i | input | 1 | Write enable, sampled with req_i |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 4 | Per-channel interrupt, equal to the pending flags |

## Verification
Both counter load paths are swept across all sixteen scales, so a wrong shift direction or a wrong mask shows up on one scale or another. Each channel's threshold is set at several values from 1 to 0xFFFE, with the counter stopped one step below the threshold and then exactly on it. This separates a >= comparison from a > comparison, shows the one-clock latency, and exposes any crossing of channels. Runs started near 0x7FFFFFFF in one-shot mode and in continuous mode show whether the wrap clears only the one-shot enable. A short channel-0 period with zero-on-compare, and a pending clear issued while a match still holds, cover the reset path and the rule that a hardware set wins.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned OFF_CFG  = 'h00;
  localparam int unsigned OFF_CNT  = 'h08;
  localparam int unsigned OFF_VIEW = 'h10;
  localparam int unsigned OFF_CMP0 = 'h20;
  localparam int unsigned BIT_ZCMP = 9;
  localparam int unsigned BIT_RUN  = 12;
  localparam int unsigned BIT_ONCE = 13;
endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned VIEW_W = 16,
  parameter int unsigned SCL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SCL_W-1:0]  scale_i,
  input  logic              raw_we_i,
  input  logic              view_we_i,
  input  logic [CNT_W-1:0]  raw_wdata_i,
  input  logic [VIEW_W-1:0] view_wdata_i,
  input  logic              zero_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [VIEW_W-1:0] view_o,
  output logic              carry_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, view_ld;

  assign view_ld = CNT_W'(view_wdata_i) << scale_i;
  assign carry_o = en_i && (&cnt_q) && !raw_we_i && !view_we_i && !zero_i;

  always_comb begin
    cnt_d = cnt_q;
    if (raw_we_i)       cnt_d = raw_wdata_i;
    else if (view_we_i) cnt_d = view_ld;
    else if (zero_i)    cnt_d = '0;
    else if (en_i)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o  = cnt_q;
  assign view_o = VIEW_W'(cnt_q >> scale_i);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !raw_we_i && !view_we_i && !zero_i) |=> $stable(cnt_q));
  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !raw_we_i && !view_we_i && !zero_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sct_channel.sv
module sct_channel #(
  parameter int unsigned VIEW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VIEW_W-1:0] view_i,
  input  logic              cmp_we_i,
  input  logic [VIEW_W-1:0] cmp_wdata_i,
  input  logic              pend_we_i,
  input  logic              pend_wbit_i,
  output logic [VIEW_W-1:0] cmp_o,
  output logic              hit_o,
  output logic              pend_o
);
  logic [VIEW_W-1:0] cmp_q;
  logic              pend_q;

  assign hit_o = view_i >= cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
      // hardware set wins over a software write
      if (hit_o)          pend_q <= 1'b1;
      else if (pend_we_i) pend_q <= pend_wbit_i;
    end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  // R8 R11
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> pend_q);
  // R11
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_we_i && !pend_wbit_i && !hit_o) |=> !pend_q);
endmodule

// File: rtl/sct_top.sv
module sct_top
  import sct_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned VIEW_W = 16,
  parameter int unsigned SCL_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int unsigned PEND_LSB = 32 - NCH;

  logic              wr, cfg_we, raw_we, view_we;
  logic [SCL_W-1:0]  scale_q;
  logic              zcmp_q, run_q, once_q;
  logic              en, zero_fire, carry;
  logic [CNT_W-1:0]  cnt;
  logic [VIEW_W-1:0] view;
  logic [NCH-1:0]    hit, pend, cmp_we;
  logic [VIEW_W-1:0] cmp [NCH];

  assign wr      = req_i && we_i;
  assign cfg_we  = wr && (addr_i == ADDR_W'(OFF_CFG));
  assign raw_we  = wr && (addr_i == ADDR_W'(OFF_CNT));
  assign view_we = wr && (addr_i == ADDR_W'(OFF_VIEW));
  assign en        = run_q || once_q;
  assign zero_fire = zcmp_q && hit[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scale_q <= '0;
      zcmp_q  <= 1'b0;
      run_q   <= 1'b0;
      once_q  <= 1'b0;
    end else if (cfg_we) begin
      scale_q <= wdata_i[SCL_W-1:0];
      zcmp_q  <= wdata_i[BIT_ZCMP];
      run_q   <= wdata_i[BIT_RUN];
      once_q  <= wdata_i[BIT_ONCE];
    end else if (carry || zero_fire) begin
      once_q  <= 1'b0;
    end

  sct_counter #(.CNT_W(CNT_W), .VIEW_W(VIEW_W), .SCL_W(SCL_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(en), .scale_i(scale_q),
    .raw_we_i(raw_we), .view_we_i(view_we),
    .raw_wdata_i(wdata_i[CNT_W-1:0]), .view_wdata_i(wdata_i[VIEW_W-1:0]),
    .zero_i(zero_fire),
    .cnt_o(cnt), .view_o(view), .carry_o(carry)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmp_we[i] = wr && (addr_i == ADDR_W'(OFF_CMP0 + 4 * i));
    sct_channel #(.VIEW_W(VIEW_W)) u_ch (
      .clk_i, .rst_ni,
      .view_i(view),
      .cmp_we_i(cmp_we[i]), .cmp_wdata_i(wdata_i[VIEW_W-1:0]),
      .pend_we_i(cfg_we), .pend_wbit_i(wdata_i[PEND_LSB + i]),
      .cmp_o(cmp[i]), .hit_o(hit[i]), .pend_o(pend[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CFG)) begin
      rdata_o[SCL_W-1:0]          = scale_q;
      rdata_o[BIT_ZCMP]           = zcmp_q;
      rdata_o[BIT_RUN]            = run_q;
      rdata_o[BIT_ONCE]           = once_q;
      rdata_o[PEND_LSB +: NCH]    = pend;
    end else if (addr_i == ADDR_W'(OFF_CNT)) begin
      rdata_o = 32'(cnt);
    end else if (addr_i == ADDR_W'(OFF_VIEW)) begin
      rdata_o = 32'(view);
    end
    for (int i = 0; i < NCH; i++)
      if (addr_i == ADDR_W'(OFF_CMP0 + 4 * i)) rdata_o = 32'(cmp[i]);
  end

  assign irq_o = pend;

  // R9
  zero_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_fire && !raw_we && !view_we) |=> (cnt == '0));
  // R9 R10
  once_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((carry || zero_fire) && !cfg_we) |=> !once_q);
  // R10
  run_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cfg_we) |=> run_q);
endmodule

// File: tb/sct_top_tb.sv
module sct_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sct_top u_dut (.clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, exp;
    // R1 during reset
    #2;
    rd(8'h00, v); check("R1 cfg in reset", v, 0);
    rd(8'h08, v); check("R1 cnt in reset", v, 0);
    check("R1 irq in reset", {28'd0, irq}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h20 + 8'(4 * i), v); check("R1 cmp in reset", v, 0);
    end
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), 32'hFFFF);
    wr(8'h00, 0);
    @(negedge clk);
    check("R1 irq idle", {28'd0, irq}, 0);

    // R2 unmapped offsets and unused cfg bits
    rd(8'h04, v); check("R2 off 04", v, 0);
    rd(8'h0C, v); check("R2 off 0C", v, 0);
    @(negedge clk);
    rd(8'h30, v); check("R2 off 30", v, 0);
    rd(8'hFC, v); check("R2 off FC", v, 0);
    wr(8'h00, 32'h0FFF0DF0);
    rd(8'h00, v); check("R2 cfg unused bits", v, 0);
    wr(8'h00, 0);

    // R7 compare width
    wr(8'h24, 32'hABCD1234);
    rd(8'h24, v); check("R7 cmp upper dropped", v, 32'h1234);
    wr(8'h24, 32'hFFFF);

    // R4 raw write, bit 31 reads zero
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08, v); check("R4 cnt bit31 zero", v, 32'h7FFFFFFF);

    // R5 R6 sweep all scales
    for (int s = 0; s < 16; s++) begin
      logic [31:0] pat, vv;
      pat = 32'h5A5AC3C3 & 32'h7FFFFFFF;
      wr(8'h00, 32'(s));
      wr(8'h08, pat);
      rd(8'h10, v); check("R5 view of raw", v, (pat >> s) & 32'hFFFF);
      vv = 32'hB00D ^ 32'(s * 32'h1111);
      wr(8'h10, vv);
      exp = (vv << s) & 32'h7FFFFFFF;
      rd(8'h08, v); check("R6 raw after view write", v, exp);
      @(negedge clk);
      rd(8'h10, v); check("R6 view after view write", v, (exp >> s) & 32'hFFFF);
    end

    // R3 increment and hold
    wr(8'h00, 0);
    wr(8'h08, 32'h100);
    wr(8'h00, 32'h1000);
    rd(8'h08, c0);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R3 run bit12", v, c0 + 10);
    wr(8'h00, 32'h2000);
    rd(8'h08, c0);
    repeat (7) @(negedge clk);
    rd(8'h08, v); check("R3 run bit13", v, c0 + 7);
    wr(8'h00, 0);
    rd(8'h08, c0);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R3 hold", v, c0);

    // R8 threshold sweep, counter stopped
    for (int ch = 0; ch < 4; ch++) begin
      logic [15:0] ks [4];
      ks = '{16'h1, 16'h80, 16'h7FFF, 16'hFFFE};
      for (int j = 0; j < 4; j++) begin
        int s;
        s = (ch * 5 + j) % 16;
        wr(8'h10, 0);
        wr(8'h20 + 8'(4 * ch), 32'(ks[j]));
        wr(8'h00, 32'(s));
        wr(8'h10, 32'(ks[j] - 16'd1));
        @(negedge clk);
        check("R8 below threshold", 32'(irq[ch]), 0);
        wr(8'h10, 32'(ks[j]));
        check("R8 not before one clock", 32'(irq[ch]), 0);
        @(negedge clk);
        check("R8 at threshold", 32'(irq[ch]), 1);
        rd(8'h00, v); check("R8 cfg pending bit", (v >> (28 + ch)) & 1, 1);
      end
      wr(8'h10, 0);
      wr(8'h20 + 8'(4 * ch), 32'hFFFF);
      wr(8'h00, 0);
    end

    // R10 one-shot wrap
    wr(8'h08, 32'h7FFFFFFC);
    wr(8'h00, 32'h2000);
    repeat (12) @(negedge clk);
    rd(8'h00, v); check("R10 oneshot cleared", v & 32'h3000, 0);
    rd(8'h08, v); check("R10 stopped at zero", v, 0);
    // R10 continuous wrap
    wr(8'h08, 32'h7FFFFFFC);
    wr(8'h00, 32'h1000);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R4 R10 wrap continues", v, 32'd6);
    rd(8'h00, v); check("R10 run kept", v & 32'h3000, 32'h1000);
    wr(8'h00, 0);
    wr(8'h08, 0);
    wr(8'h00, 0);

    // R9 zero on compare, channel 0
    wr(8'h20, 32'd5);
    wr(8'h00, 32'h2200);
    repeat (20) @(negedge clk);
    rd(8'h08, v); check("R9 counter zeroed", v, 0);
    rd(8'h00, v); check("R9 cfg after fire", v, 32'h10000200);
    check("R9 irq ch0 only", {28'd0, irq}, 4'b0001);
    wr(8'h20, 32'hFFFF);
    wr(8'h00, 0);
    @(negedge clk);
    check("R11 clear ch0", {28'd0, irq}, 0);

    // R11 hardware set wins
    wr(8'h24, 0);
    @(negedge clk);
    check("R11 ch1 pending", 32'(irq[1]), 1);
    wr(8'h00, 0);
    check("R11 set wins over clear", 32'(irq[1]), 1);
    wr(8'h24, 32'hFFFF);
    wr(8'h00, 0);
    check("R11 clear after match gone", 32'(irq[1]), 0);

    finish_run();
  end
endmodule